// File: doc/BRIEF.md
# Multi-Port Register File with Pointer Pairs

This block is the working-register store of a small RISC core: thirty-two 8-bit registers that the core reads through two independent byte ports and one 16-bit pair port, and writes through an 8-bit result path and a 16-bit result path. Together these cover every operand scheme the core uses. A single byte operand pairs with a byte result. Two byte operands pair with a byte result or with a 16-bit result. A 16-bit pair operand pairs with a 16-bit result. A 16-bit value always sits in an even/odd pair: the even register holds the low byte and the odd register holds the high byte.

The top six registers double as three 16-bit indirect address pointers (pairs 26/27, 28/29 and 30/31). They are driven on dedicated outputs straight from the storage. The same storage also answers on a data-space port at addresses 0x00 to 0x1F, so a load/store unit can reach any register through a pointer value. That port uses a valid/ready handshake. A transfer happens on a cycle with both valid and ready high. Ready drops only when a data-space write targets a register that a core write also hits in the same cycle. The requester must then hold its address, data and valid until ready returns, which happens on the next cycle because the core's write has already landed.

Top module: `gpr_file`

## Requirements
- R1: After reset every register reads 0, and so do all three pointer outputs.
- R2: Ports A and B read any two registers combinationally and independently of each other, including the same register on both ports.
- R3: An 8-bit core write lands at the rising clock edge. A read of that register in the same cycle returns the value it held before the write.
- R4: A 16-bit core write ignores bit 0 of its index. Bits 7:0 go to the even register and bits 15:8 go to the odd register above it.
- R5: The pair read port ignores bit 0 of its index and returns {odd register, even register}.
- R6: Pointer X is {r27,r26}, pointer Y is {r29,r28} and pointer Z is {r31,r30}. Each follows the registers in the cycle after any write.
- R7: On the data-space port, addresses 0x0000 to 0x001F set ds_hit to 1 and return register n at address n. Any higher address gives ds_hit = 0 and ds_rdata = 0.
- R8: A data-space write lands at the clock edge when ds_valid, ds_ready and ds_we are high and the address hits. A write to an address that misses changes no register, including the register its low five bits would alias to.
- R9: ds_ready is 0 exactly when a data-space write hits a register that a core write targets in the same cycle. The core value lands in that cycle, and the held data-space write lands in the following cycle.
- R10: When the 8-bit and 16-bit core writes hit the same register in one cycle, the byte from the 16-bit write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Byte read port A register index |
| rd_a_data | output | 8 | Byte read port A data |
| rd_b_idx | input | 5 | Byte read port B register index |
| rd_b_data | output | 8 | Byte read port B data |
| rd_pair_idx | input | 5 | Pair read index (bit 0 ignored) |
| rd_pair_data | output | 16 | Pair read data {odd, even} |
| wr8_en | input | 1 | 8-bit core write enable |
| wr8_idx | input | 5 | 8-bit core write index |
| wr8_data | input | 8 | 8-bit core write data |
| wr16_en | input | 1 | 16-bit core write enable |
| wr16_idx | input | 5 | 16-bit core write index (bit 0 ignored) |
| wr16_data | input | 16 | 16-bit core write data |
| ds_valid | input | 1 | Data-space request valid |
| ds_ready | output | 1 | Data-space request accepted |
| ds_we | input | 1 | Data-space request is a write |
| ds_addr | input | 16 | Data-space byte address |
| ds_wdata | input | 8 | Data-space write data |
| ds_hit | output | 1 | Address falls inside the register window |
| ds_rdata | output | 8 | Data-space read data |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |
| ptr_z | output | 16 | Pointer Z |

## Verification
The bench reads a register in the same cycle that it is written. A design with a write-through bypass would return the new value there instead of the old one. It issues a 16-bit write with an odd index, which a design that fails to force the even base would spread across the wrong pair, and it overlaps 8-bit and 16-bit writes on one register to expose a reversed priority. On the data-space side it writes to address 0x0040, whose low bits alias register 0, to catch a window check that only decodes five bits. It also collides a data-space write with a core write: a design without back-pressure would either lose the data-space byte or overwrite the core value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_COUNT = 32;
  localparam int unsigned GPR_WIDTH = 8;
  localparam int unsigned DS_ADDR_WIDTH = 16;
  localparam int unsigned PTR_FIRST = 26;
  localparam int unsigned PTR_COUNT = 3;
endpackage

// File: rtl/gpr_wdecode.sv
module gpr_wdecode #(
  parameter int unsigned N_REGS = 32,
  parameter int unsigned REG_W  = 8,
  localparam int unsigned IDX_W = $clog2(N_REGS)
) (
  input  logic                          wr8_en,
  input  logic [IDX_W-1:0]              wr8_idx,
  input  logic [REG_W-1:0]              wr8_data,
  input  logic                          wr16_en,
  input  logic [IDX_W-1:0]              wr16_idx,
  input  logic [2*REG_W-1:0]            wr16_data,
  output logic [N_REGS-1:0]             core_we,
  output logic [N_REGS-1:0][REG_W-1:0]  core_wd
);
  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;

  // The 16-bit path always addresses an even/odd pair.
  assign lo_idx = wr16_idx & ~IDX_W'(1);
  assign hi_idx = lo_idx | IDX_W'(1);

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    logic             we_i;
    logic [REG_W-1:0] wd_i;
    always_comb begin
      we_i = 1'b0;
      wd_i = wr8_data;
      if (wr8_en && (wr8_idx == IDX_W'(i))) we_i = 1'b1;
      // The 16-bit result overrides the byte result on overlap (R10).
      if (wr16_en && (lo_idx == IDX_W'(i))) begin
        we_i = 1'b1;
        wd_i = wr16_data[REG_W-1:0];
      end else if (wr16_en && (hi_idx == IDX_W'(i))) begin
        we_i = 1'b1;
        wd_i = wr16_data[2*REG_W-1:REG_W];
      end
    end
    assign core_we[i] = we_i;
    assign core_wd[i] = wd_i;
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned N_REGS = 32,
  parameter int unsigned REG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REGS-1:0]             core_we,
  input  logic [N_REGS-1:0][REG_W-1:0]  core_wd,
  input  logic [N_REGS-1:0]             ds_we,
  input  logic [REG_W-1:0]              ds_wd,
  output logic [N_REGS-1:0][REG_W-1:0]  regs
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs[i] <= '0;
      else if (core_we[i]) regs[i] <= core_wd[i];
      else if (ds_we[i])   regs[i] <= ds_wd;
    end
  end

  // The data-space side writes at most one register per cycle.
  assert_ds_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ds_we));

  // The handshake must never hand the store a data-space write that a core write hits.
  assert_no_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_we & core_we) == '0);
endmodule

// File: rtl/gpr_rdmux.sv
module gpr_rdmux #(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned ENT_W = 8,
  localparam int unsigned SEL_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0][ENT_W-1:0] table_in,
  input  logic [SEL_W-1:0]            sel,
  output logic [ENT_W-1:0]            q
);
  assign q = table_in[sel];
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int unsigned N_REGS = GPR_COUNT,
  parameter int unsigned REG_W  = GPR_WIDTH,
  parameter int unsigned DS_AW  = DS_ADDR_WIDTH,
  parameter int unsigned PTR_LO = PTR_FIRST,
  parameter int unsigned N_PTRS = PTR_COUNT,
  localparam int unsigned IDX_W = $clog2(N_REGS),
  localparam int unsigned PAIR_W = 2 * REG_W,
  localparam int unsigned N_PAIRS = N_REGS / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [REG_W-1:0]  rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [REG_W-1:0]  rd_b_data,
  input  logic [IDX_W-1:0]  rd_pair_idx,
  output logic [PAIR_W-1:0] rd_pair_data,
  input  logic              wr8_en,
  input  logic [IDX_W-1:0]  wr8_idx,
  input  logic [REG_W-1:0]  wr8_data,
  input  logic              wr16_en,
  input  logic [IDX_W-1:0]  wr16_idx,
  input  logic [PAIR_W-1:0] wr16_data,
  input  logic              ds_valid,
  output logic              ds_ready,
  input  logic              ds_we,
  input  logic [DS_AW-1:0]  ds_addr,
  input  logic [REG_W-1:0]  ds_wdata,
  output logic              ds_hit,
  output logic [REG_W-1:0]  ds_rdata,
  output logic [PAIR_W-1:0] ptr_x,
  output logic [PAIR_W-1:0] ptr_y,
  output logic [PAIR_W-1:0] ptr_z
);
  logic [N_REGS-1:0][REG_W-1:0]   regs;
  logic [N_PAIRS-1:0][PAIR_W-1:0] pairs;
  logic [N_REGS-1:0]              core_we;
  logic [N_REGS-1:0][REG_W-1:0]   core_wd;
  logic [N_REGS-1:0]              ds_we_mask;
  logic [IDX_W-1:0]               ds_idx;
  logic [REG_W-1:0]               ds_word;
  logic [IDX_W-1:0]               pair_sel;
  logic [N_PTRS-1:0][PAIR_W-1:0]  ptrs;
  logic                           ds_fire;

  // The packed layout gives {odd, even} per pair.
  assign pairs = regs;

  gpr_wdecode #(.N_REGS(N_REGS), .REG_W(REG_W)) u_wdec (
    .wr8_en(wr8_en), .wr8_idx(wr8_idx), .wr8_data(wr8_data),
    .wr16_en(wr16_en), .wr16_idx(wr16_idx), .wr16_data(wr16_data),
    .core_we(core_we), .core_wd(core_wd)
  );

  // Data-space window decode over the full address width.
  assign ds_hit   = (ds_addr < DS_AW'(N_REGS));
  assign ds_idx   = ds_addr[IDX_W-1:0];
  assign ds_ready = !(ds_we && ds_hit && core_we[ds_idx]);
  assign ds_fire  = ds_valid && ds_ready && ds_we && ds_hit;

  always_comb begin
    ds_we_mask = '0;
    if (ds_fire) ds_we_mask[ds_idx] = 1'b1;
  end

  gpr_store #(.N_REGS(N_REGS), .REG_W(REG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .core_we(core_we), .core_wd(core_wd),
    .ds_we(ds_we_mask), .ds_wd(ds_wdata),
    .regs(regs)
  );

  gpr_rdmux #(.N_ENT(N_REGS), .ENT_W(REG_W)) u_rd_a (
    .table_in(regs), .sel(rd_a_idx), .q(rd_a_data));
  gpr_rdmux #(.N_ENT(N_REGS), .ENT_W(REG_W)) u_rd_b (
    .table_in(regs), .sel(rd_b_idx), .q(rd_b_data));
  gpr_rdmux #(.N_ENT(N_REGS), .ENT_W(REG_W)) u_rd_ds (
    .table_in(regs), .sel(ds_idx), .q(ds_word));

  assign ds_rdata = ds_hit ? ds_word : '0;

  // The pair port discards bit 0 of its index.
  assign pair_sel = rd_pair_idx >> 1;
  gpr_rdmux #(.N_ENT(N_PAIRS), .ENT_W(PAIR_W)) u_rd_pair (
    .table_in(pairs), .sel(pair_sel[IDX_W-2:0]), .q(rd_pair_data));

  for (genvar p = 0; p < N_PTRS; p++) begin : g_ptr
    assign ptrs[p] = pairs[PTR_LO/2 + p];
  end
  assign ptr_x = ptrs[0];
  assign ptr_y = ptrs[1];
  assign ptr_z = ptrs[2];

  // ---------------- assertions ----------------
  assert_wr8_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8_en && !wr16_en) |=> regs[$past(wr8_idx)] == $past(wr8_data));

  assert_wr16_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr16_en |=> pairs[$past(wr16_idx >> 1)] == $past(wr16_data));

  assert_ptr_x_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en && ((wr16_idx >> 1) == IDX_W'(PTR_LO/2))) |=> ptr_x == $past(wr16_data));

  assert_ds_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_addr >= DS_AW'(N_REGS)) |-> (!ds_hit && ds_rdata == '0));

  assert_stall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_ready |-> (ds_we && ds_hit && core_we[ds_idx]));

  assert_core_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_valid && !ds_ready) |=> regs[$past(ds_idx)] == $past(core_wd[ds_idx]));

  assert_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8_en && wr16_en && ((wr8_idx >> 1) == (wr16_idx >> 1)))
      |=> pairs[$past(wr16_idx >> 1)] == $past(wr16_data));
endmodule

// File: tb/sim_gpr_file.sv
`timescale 1ns/1ps
module sim_gpr_file;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, rd_pair_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data;
  logic [15:0] rd_pair_data;
  logic        wr8_en = 1'b0, wr16_en = 1'b0;
  logic [4:0]  wr8_idx = '0, wr16_idx = '0;
  logic [7:0]  wr8_data = '0;
  logic [15:0] wr16_data = '0;
  logic        ds_valid = 1'b0, ds_we = 1'b0;
  logic        ds_ready, ds_hit;
  logic [15:0] ds_addr = '0;
  logic [7:0]  ds_wdata = '0, ds_rdata;
  logic [15:0] ptr_x, ptr_y, ptr_z;

  always #5 clk = ~clk;

  gpr_file u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .rd_pair_idx(rd_pair_idx), .rd_pair_data(rd_pair_data),
    .wr8_en(wr8_en), .wr8_idx(wr8_idx), .wr8_data(wr8_data),
    .wr16_en(wr16_en), .wr16_idx(wr16_idx), .wr16_data(wr16_data),
    .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_we(ds_we),
    .ds_addr(ds_addr), .ds_wdata(ds_wdata), .ds_hit(ds_hit), .ds_rdata(ds_rdata),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
  );

  typedef enum int {P_A, P_B, P_PAIR, P_X, P_Y, P_Z, P_DSD, P_HIT, P_RDY} port_e;
  typedef struct { port_e port; logic [15:0] exp; string req; } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [32];
  bit done = 1'b0;

  function automatic logic [15:0] observe(port_e p);
    case (p)
      P_A:    return {8'h00, rd_a_data};
      P_B:    return {8'h00, rd_b_data};
      P_PAIR: return rd_pair_data;
      P_X:    return ptr_x;
      P_Y:    return ptr_y;
      P_Z:    return ptr_z;
      P_DSD:  return {8'h00, ds_rdata};
      P_HIT:  return {15'h0, ds_hit};
      default: return {15'h0, ds_ready};
    endcase
  endfunction

  task automatic expect_val(port_e p, logic [15:0] e, string req);
    item_t it;
    it.port = p; it.exp = e; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor: samples mid-cycle, after the driver has set up the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = sb.pop_front();
        got = observe(it.port);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s port=%s actual=%h expected=%h", it.req, it.port.name(), got, it.exp);
        end
      end
    end
  end

  task automatic do_wr8(input logic [4:0] i, input logic [7:0] d);
    wr8_en = 1'b1; wr8_idx = i; wr8_data = d;
    tick();
    wr8_en = 1'b0;
    mdl[i] = d;
  endtask

  task automatic do_wr16(input logic [4:0] i, input logic [15:0] d);
    wr16_en = 1'b1; wr16_idx = i; wr16_data = d;
    tick();
    wr16_en = 1'b0;
    mdl[{i[4:1], 1'b0}] = d[7:0];
    mdl[{i[4:1], 1'b1}] = d[15:8];
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    tick();
    // R1: reset state
    rd_a_idx = 5'd0; rd_b_idx = 5'd31;
    expect_val(P_A, 16'h0, "R1");
    expect_val(P_B, 16'h0, "R1");
    expect_val(P_X, 16'h0, "R1");
    expect_val(P_Y, 16'h0, "R1");
    expect_val(P_Z, 16'h0, "R1");
    tick();
    rst_n = 1'b1;
    tick();

    // R3: fill every register through the byte path
    for (int i = 0; i < 32; i++) do_wr8(5'(i), 8'((i * 37 + 11) & 8'hFF));
    // R2: read all registers through both ports in opposite orders
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
      expect_val(P_A, {8'h0, mdl[i]}, "R2");
      expect_val(P_B, {8'h0, mdl[31 - i]}, "R2");
      tick();
    end
    rd_a_idx = 5'd9; rd_b_idx = 5'd9;
    expect_val(P_A, {8'h0, mdl[9]}, "R2");
    expect_val(P_B, {8'h0, mdl[9]}, "R2");
    tick();

    // R3: same-cycle read returns the old value, next cycle the new one
    rd_a_idx = 5'd5;
    wr8_en = 1'b1; wr8_idx = 5'd5; wr8_data = 8'hC3;
    expect_val(P_A, {8'h0, mdl[5]}, "R3");
    tick();
    wr8_en = 1'b0; mdl[5] = 8'hC3;
    expect_val(P_A, 16'h00C3, "R3");
    tick();

    // R4/R6: 16-bit writes into the pointer pairs, one with an odd index
    do_wr16(5'd26, 16'hBEEF);
    do_wr16(5'd29, 16'h1234);
    do_wr16(5'd30, 16'h8001);
    expect_val(P_X, 16'hBEEF, "R6");
    expect_val(P_Y, 16'h1234, "R6");
    expect_val(P_Z, 16'h8001, "R6");
    rd_a_idx = 5'd28; rd_b_idx = 5'd29;
    expect_val(P_A, 16'h0034, "R4");
    expect_val(P_B, 16'h0012, "R4");
    tick();
    // R4: odd index must leave the pair above untouched
    rd_a_idx = 5'd30;
    expect_val(P_A, 16'h0001, "R4");
    tick();

    // R5: pair read, bit 0 of the index ignored
    rd_pair_idx = 5'd3;
    expect_val(P_PAIR, {mdl[3], mdl[2]}, "R5");
    tick();
    rd_pair_idx = 5'd26;
    expect_val(P_PAIR, 16'hBEEF, "R5");
    tick();

    // R7: data-space window
    ds_addr = 16'h0005;
    expect_val(P_HIT, 16'h1, "R7");
    expect_val(P_DSD, {8'h0, mdl[5]}, "R7");
    tick();
    ds_addr = 16'h001F;
    expect_val(P_DSD, {8'h0, mdl[31]}, "R7");
    tick();
    ds_addr = 16'h0020;
    expect_val(P_HIT, 16'h0, "R7");
    expect_val(P_DSD, 16'h0, "R7");
    tick();

    // R8: data-space write that hits
    ds_valid = 1'b1; ds_we = 1'b1; ds_addr = 16'h000A; ds_wdata = 8'h5A;
    expect_val(P_RDY, 16'h1, "R9");
    tick();
    ds_valid = 1'b0; ds_we = 1'b0; mdl[10] = 8'h5A;
    rd_a_idx = 5'd10;
    expect_val(P_A, 16'h005A, "R8");
    tick();
    // R8: a miss that aliases register 0 changes nothing
    ds_valid = 1'b1; ds_we = 1'b1; ds_addr = 16'h0040; ds_wdata = 8'hEE;
    tick();
    ds_valid = 1'b0; ds_we = 1'b0;
    rd_a_idx = 5'd0;
    expect_val(P_A, {8'h0, mdl[0]}, "R8");
    tick();

    // R9: collision between a data-space write and a core write
    ds_valid = 1'b1; ds_we = 1'b1; ds_addr = 16'h0007; ds_wdata = 8'h55;
    wr8_en = 1'b1; wr8_idx = 5'd7; wr8_data = 8'hAA;
    expect_val(P_RDY, 16'h0, "R9");
    tick();
    wr8_en = 1'b0;
    rd_a_idx = 5'd7;
    expect_val(P_RDY, 16'h1, "R9");
    expect_val(P_A, 16'h00AA, "R9");
    tick();
    ds_valid = 1'b0; ds_we = 1'b0; mdl[7] = 8'h55;
    expect_val(P_A, 16'h0055, "R9");
    tick();
    // R9: collision against the high byte of a 16-bit write
    ds_valid = 1'b1; ds_we = 1'b1; ds_addr = 16'h0013; ds_wdata = 8'h77;
    wr16_en = 1'b1; wr16_idx = 5'd18; wr16_data = 16'h6655;
    expect_val(P_RDY, 16'h0, "R9");
    tick();
    wr16_en = 1'b0;
    tick();
    ds_valid = 1'b0; ds_we = 1'b0;
    rd_pair_idx = 5'd18;
    expect_val(P_PAIR, 16'h7755, "R9");
    tick();

    // R10: overlapping byte and 16-bit writes
    wr8_en = 1'b1; wr8_idx = 5'd12; wr8_data = 8'h11;
    wr16_en = 1'b1; wr16_idx = 5'd12; wr16_data = 16'hA5C7;
    tick();
    wr8_en = 1'b0; wr16_en = 1'b0;
    rd_a_idx = 5'd12; rd_b_idx = 5'd13;
    expect_val(P_A, 16'h00C7, "R10");
    expect_val(P_B, 16'h00A5, "R10");
    tick();
    wr8_en = 1'b1; wr8_idx = 5'd13; wr8_data = 8'h22;
    wr16_en = 1'b1; wr16_idx = 5'd12; wr16_data = 16'h3C4D;
    tick();
    wr8_en = 1'b0; wr16_en = 1'b0;
    expect_val(P_B, 16'h003C, "R10");
    tick();
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule